// File: doc/BRIEF.md
# Registered-Mode Command Retiming Stage

This block sits between a memory controller and the command and address pins of a synchronous DRAM. It models the register stage that a registered memory module places in the command path. One input selects the mode. In registered mode, the chip select, row and column strobes, write enable, clock enable, bank, address and byte-lane masks are captured on the rising clock edge and reach the DRAM one cycle later. In transparent mode, they pass straight through in the same cycle.

The DRAM data lanes bypass the register. For that reason, the block also retimes both data directions so that the controller sees consistent latencies in either mode:
- It reports the effective read latency.
- It raises per-lane read-capture strobes on the cycles where valid read data is expected, honouring the two-cycle read mask.
- It raises per-lane write-enable strobes on the cycles where the controller must drive write data, honouring the same-cycle write mask.

A mode select that is not driven high falls back to registered operation.

Top module: `dimm_cmd_retimer`

## Requirements
- R1: While reset is asserted in registered mode, the DRAM-side outputs show a deselected idle command: chip select high, all three strobes high, clock enable low and all mask lanes high. Both strobe vectors are zero.
- R2: In registered mode, chip select, the three strobes, bank, address and mask driven in controller cycle t appear on the DRAM-side outputs in cycle t+1, and not in cycle t.
- R3: In transparent mode, the DRAM-side command, bank and address outputs equal the controller inputs in the same cycle.
- R4: The read-latency output equals the CAS latency input plus one in registered mode, and equals the CAS latency in transparent mode.
- R5: A read is encoded as {cs_n,ras_n,cas_n,we_n} = 0101. A read issued in controller cycle t makes rd_lane_vld nonzero in exactly the BURST_LEN cycles that start at t plus the read latency of R4.
- R6: A mask lane that is high on the DRAM-side outputs in cycle e clears that lane of rd_lane_vld in cycle e+2, and in no other cycle.
- R7: The clock enable follows the same path as the commands. In registered mode, a low clock enable reaches the DRAM side one cycle later.
- R8: A write is encoded as 0100. Write beats run for BURST_LEN cycles, starting in the cycle the write reaches the DRAM side. The write data output equals the controller write data in that same cycle, in both modes.
- R9: In every write beat, wr_lane_en equals the inverse of the DRAM-side mask in that same cycle. Outside write beats, it is zero.
- R10: A mode select held low, unknown or undriven gives registered behaviour. Only a definite high selects transparent mode.
- R11: A read issued while an earlier read burst is still running restarts the beat count. Beats then continue without a gap through the end of the new burst.
- R12: When the mode changes in a cycle where the controller drives NOP (0111), and drove NOP in the cycle before, the DRAM-side command in the switch cycle is NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bypass | input | 1 | High selects transparent mode; anything else selects registered mode |
| cas_lat | input | CL_W | DRAM CAS latency in clocks, from 1 to MAX_CL |
| c_cs_n | input | 1 | Controller chip select, active low |
| c_ras_n | input | 1 | Controller row strobe, active low |
| c_cas_n | input | 1 | Controller column strobe, active low |
| c_we_n | input | 1 | Controller write enable, active low |
| c_cke | input | 1 | Controller clock enable |
| c_ba | input | BA_W | Controller bank select |
| c_addr | input | ADDR_W | Controller multiplexed address |
| c_dqm | input | LANES | Controller byte-lane mask |
| c_wdata | input | LANES*LANE_W | Controller write data |
| d_cs_n | output | 1 | DRAM-side chip select |
| d_ras_n | output | 1 | DRAM-side row strobe |
| d_cas_n | output | 1 | DRAM-side column strobe |
| d_we_n | output | 1 | DRAM-side write enable |
| d_cke | output | 1 | DRAM-side clock enable |
| d_ba | output | BA_W | DRAM-side bank select |
| d_addr | output | ADDR_W | DRAM-side address |
| d_dqm | output | LANES | DRAM-side byte-lane mask |
| d_wdata | output | LANES*LANE_W | DRAM-side write data (never registered) |
| rd_lat | output | CL_W+1 | Effective read latency seen by the controller |
| rd_lane_vld | output | LANES | Per-lane read-data capture strobe |
| wr_lane_en | output | LANES | Per-lane write-data strobe |

## Verification
Two events can land in the same cycle: the first beat of a second, back-to-back read burst, and a read mask issued together with that second read. This case is provoked by issuing two reads two cycles apart in registered mode, with the mask raised on a subset of lanes in the cycle of the second read. The bench then expects an unbroken six-beat strobe run in which only the restarted burst's first beat has the masked lanes cleared. That single cycle shows whether the truncation restart and the two-cycle mask pipe are aligned to each other and to the extra register cycle.

// File: rtl/dimm_retime_pkg.sv
package dimm_retime_pkg;

   typedef enum logic [1:0] {
      CK_NOP,
      CK_READ,
      CK_WRITE,
      CK_OTHER
   } cmd_kind_e;

   // Decode of {cs_n, ras_n, cas_n, we_n}
   function automatic cmd_kind_e classify(input logic cs_n, input logic ras_n,
                                          input logic cas_n, input logic we_n);
      cmd_kind_e k;
      if (cs_n) begin
         k = CK_NOP;
      end else begin
         case ({ras_n, cas_n, we_n})
            3'b111:  k = CK_NOP;
            3'b101:  k = CK_READ;
            3'b100:  k = CK_WRITE;
            default: k = CK_OTHER;
         endcase
      end
      return k;
   endfunction

endpackage

// File: rtl/retime_cmd_stage.sv
module retime_cmd_stage #(
   parameter int            W            = 8,
   parameter logic [W-1:0]  RST_VAL      = '0,
   parameter bit            ALLOW_BYPASS = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         bypass,
   input  logic [W-1:0] in_bus,
   output logic [W-1:0] out_bus
);

   logic [W-1:0] q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_VAL;
      else        q <= in_bus;
   end

   logic live;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live <= 1'b0;
      else        live <= 1'b1;
   end

   generate
      if (ALLOW_BYPASS) begin : g_mux
         assign out_bus = bypass ? in_bus : q;

         // R2: registered path delays by exactly one clock
         a_r2_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
            live && !bypass && $past(!bypass) |-> out_bus == $past(in_bus));

         // R3: transparent path has no delay
         a_r3_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
            bypass |-> out_bus == in_bus);
      end else begin : g_fixed
         logic unused_bypass;
         assign unused_bypass = bypass;
         assign out_bus = q;

         a_r2_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
            live |-> out_bus == $past(in_bus));
      end
   endgenerate

endmodule

// File: rtl/retime_rd_align.sv
module retime_rd_align #(
   parameter int LANES     = 8,
   parameter int BURST_LEN = 4,
   parameter int MAX_CL    = 3,
   parameter int CL_W      = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             is_read,
   input  logic [CL_W-1:0]  cas_lat,
   input  logic [LANES-1:0] dqm,
   output logic [LANES-1:0] lane_vld
);

   logic [MAX_CL-1:0] dline;
   logic              tap;
   logic              beat;
   logic [LANES-1:0]  dq1, dq2;

   generate
      if (MAX_CL == 1) begin : g_dl1
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) dline <= '0;
            else        dline <= is_read;
         end
      end else begin : g_dln
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) dline <= '0;
            else        dline <= {dline[MAX_CL-2:0], is_read};
         end
      end
   endgenerate

   always_comb begin
      tap = 1'b0;
      for (int i = 0; i < MAX_CL; i++) begin
         if (cas_lat == CL_W'(i + 1)) tap = dline[i];
      end
   end

   // Two-cycle read mask pipe
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dq1 <= '1;
         dq2 <= '1;
      end else begin
         dq1 <= dqm;
         dq2 <= dq1;
      end
   end

   generate
      if (BURST_LEN == 1) begin : g_single
         assign beat = tap;
      end else begin : g_burst
         localparam int CNT_W = $clog2(BURST_LEN);
         logic [CNT_W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           cnt <= '0;
            else if (tap)         cnt <= CNT_W'(BURST_LEN - 1);
            else if (cnt != '0)   cnt <= cnt - 1'b1;
         end
         assign beat = tap || (cnt != '0);

         // R5: a burst start is followed by a further beat
         a_r5_burst_continues: assert property (@(posedge clk) disable iff (!rst_n)
            tap |=> beat);
      end
   endgenerate

   assign lane_vld = beat ? ~dq2 : '0;

   logic [1:0] age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          age <= '0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   // R6: a lane masked two cycles ago is never strobed
   a_r6_read_mask: assert property (@(posedge clk) disable iff (!rst_n)
      age >= 2'd2 |-> (lane_vld & $past(dqm, 2)) == '0);

endmodule

// File: rtl/retime_wr_align.sv
module retime_wr_align #(
   parameter int LANES     = 8,
   parameter int BURST_LEN = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             is_write,
   input  logic [LANES-1:0] dqm,
   output logic [LANES-1:0] lane_en
);

   logic beat;

   generate
      if (BURST_LEN == 1) begin : g_single
         assign beat = is_write;
      end else begin : g_burst
         localparam int CNT_W = $clog2(BURST_LEN);
         logic [CNT_W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          cnt <= '0;
            else if (is_write)   cnt <= CNT_W'(BURST_LEN - 1);
            else if (cnt != '0)  cnt <= cnt - 1'b1;
         end
         assign beat = is_write || (cnt != '0);

         // R8: a write occupies more than its command cycle
         a_r8_write_burst: assert property (@(posedge clk) disable iff (!rst_n)
            is_write |=> lane_en != '0 || dqm == '1);
      end
   endgenerate

   assign lane_en = beat ? ~dqm : '0;

   // R9: write mask acts in the command's own cycle
   a_r9_write_mask: assert property (@(posedge clk) disable iff (!rst_n)
      is_write |-> lane_en == ~dqm);

endmodule

// File: rtl/dimm_cmd_retimer.sv
module dimm_cmd_retimer
   import dimm_retime_pkg::*;
#(
   parameter int ADDR_W       = 13,
   parameter int BA_W         = 2,
   parameter int LANES        = 8,
   parameter int LANE_W       = 8,
   parameter int BURST_LEN    = 4,
   parameter int MAX_CL       = 3,
   parameter int CL_W         = $clog2(MAX_CL + 1),
   parameter bit ALLOW_BYPASS = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bypass,
   input  logic [CL_W-1:0]         cas_lat,
   input  logic                    c_cs_n,
   input  logic                    c_ras_n,
   input  logic                    c_cas_n,
   input  logic                    c_we_n,
   input  logic                    c_cke,
   input  logic [BA_W-1:0]         c_ba,
   input  logic [ADDR_W-1:0]       c_addr,
   input  logic [LANES-1:0]        c_dqm,
   input  logic [LANES*LANE_W-1:0] c_wdata,
   output logic                    d_cs_n,
   output logic                    d_ras_n,
   output logic                    d_cas_n,
   output logic                    d_we_n,
   output logic                    d_cke,
   output logic [BA_W-1:0]         d_ba,
   output logic [ADDR_W-1:0]       d_addr,
   output logic [LANES-1:0]        d_dqm,
   output logic [LANES*LANE_W-1:0] d_wdata,
   output logic [CL_W:0]           rd_lat,
   output logic [LANES-1:0]        rd_lane_vld,
   output logic [LANES-1:0]        wr_lane_en
);

   localparam int BUS_W = 5 + BA_W + ADDR_W + LANES;
   localparam logic [BUS_W-1:0] IDLE_VAL =
      {5'b11110, {BA_W{1'b0}}, {ADDR_W{1'b0}}, {LANES{1'b1}}};

   generate
      if (ADDR_W < 1 || BA_W < 1 || LANES < 1 || LANE_W < 1)
         $error("retimer: widths must be positive");
      if (BURST_LEN < 1 || MAX_CL < 1)
         $error("retimer: burst length and max latency must be positive");
      if ((1 << CL_W) <= MAX_CL)
         $error("retimer: CL_W too narrow for MAX_CL");
   endgenerate

   // Only a definite high selects transparent operation
   logic bypass_sel;
   assign bypass_sel = ALLOW_BYPASS && (bypass === 1'b1);

   logic [BUS_W-1:0] c_bus, d_bus;
   assign c_bus = {c_cs_n, c_ras_n, c_cas_n, c_we_n, c_cke, c_ba, c_addr, c_dqm};

   retime_cmd_stage #(
      .W            (BUS_W),
      .RST_VAL      (IDLE_VAL),
      .ALLOW_BYPASS (ALLOW_BYPASS)
   ) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .bypass  (bypass_sel),
      .in_bus  (c_bus),
      .out_bus (d_bus)
   );

   assign {d_cs_n, d_ras_n, d_cas_n, d_we_n, d_cke, d_ba, d_addr, d_dqm} = d_bus;

   // Data lanes never pass through the register
   assign d_wdata = c_wdata;

   assign rd_lat = {1'b0, cas_lat} + {{CL_W{1'b0}}, ~bypass_sel};

   cmd_kind_e d_kind, c_kind;
   assign d_kind = classify(d_cs_n, d_ras_n, d_cas_n, d_we_n);
   assign c_kind = classify(c_cs_n, c_ras_n, c_cas_n, c_we_n);

   retime_rd_align #(
      .LANES     (LANES),
      .BURST_LEN (BURST_LEN),
      .MAX_CL    (MAX_CL),
      .CL_W      (CL_W)
   ) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .is_read  (d_kind == CK_READ),
      .cas_lat  (cas_lat),
      .dqm      (d_dqm),
      .lane_vld (rd_lane_vld)
   );

   retime_wr_align #(
      .LANES     (LANES),
      .BURST_LEN (BURST_LEN)
   ) u_wr (
      .clk      (clk),
      .rst_n    (rst_n),
      .is_write (d_kind == CK_WRITE),
      .dqm      (d_dqm),
      .lane_en  (wr_lane_en)
   );

   logic live;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live <= 1'b0;
      else        live <= 1'b1;
   end

   // R12: mode changes only across NOP cycles
   a_r12_switch_on_nop: assert property (@(posedge clk) disable iff (!rst_n)
      live && !$stable(bypass_sel) |-> c_kind == CK_NOP && $past(c_kind == CK_NOP));

   // R4: latency input stays in the supported range
   a_r4_cl_legal: assert property (@(posedge clk) disable iff (!rst_n)
      cas_lat >= CL_W'(1) && cas_lat <= CL_W'(MAX_CL));

endmodule

// File: tb/dimm_cmd_retimer_bench.sv
`timescale 1ns/100ps
module dimm_cmd_retimer_bench;

   localparam int ADDR_W = 13, BA_W = 2, LANES = 8, LANE_W = 8, BL = 4, MAX_CL = 3;
   localparam int CL_W = 2;
   localparam logic [3:0] NOP = 4'b0111, RD = 4'b0101, WR = 4'b0100, ACT = 4'b0011;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bypass = 1'b0;
   logic [CL_W-1:0] cas_lat = 2'd2;
   logic c_cs_n = 1'b0, c_ras_n = 1'b1, c_cas_n = 1'b1, c_we_n = 1'b1, c_cke = 1'b1;
   logic [BA_W-1:0] c_ba = 2'b01;
   logic [ADDR_W-1:0] c_addr = '0;
   logic [LANES-1:0] c_dqm = '0;
   logic [LANES*LANE_W-1:0] c_wdata = '0;
   logic d_cs_n, d_ras_n, d_cas_n, d_we_n, d_cke;
   logic [BA_W-1:0] d_ba;
   logic [ADDR_W-1:0] d_addr;
   logic [LANES-1:0] d_dqm, rd_lane_vld, wr_lane_en;
   logic [LANES*LANE_W-1:0] d_wdata;
   logic [CL_W:0] rd_lat;

   int n_chk = 0, n_fail = 0;

   always #2.5 clk = ~clk;

   dimm_cmd_retimer u_dimm_cmd_retimer (
      .clk(clk), .rst_n(rst_n), .bypass(bypass), .cas_lat(cas_lat),
      .c_cs_n(c_cs_n), .c_ras_n(c_ras_n), .c_cas_n(c_cas_n), .c_we_n(c_we_n),
      .c_cke(c_cke), .c_ba(c_ba), .c_addr(c_addr), .c_dqm(c_dqm), .c_wdata(c_wdata),
      .d_cs_n(d_cs_n), .d_ras_n(d_ras_n), .d_cas_n(d_cas_n), .d_we_n(d_we_n),
      .d_cke(d_cke), .d_ba(d_ba), .d_addr(d_addr), .d_dqm(d_dqm), .d_wdata(d_wdata),
      .rd_lat(rd_lat), .rd_lane_vld(rd_lane_vld), .wr_lane_en(wr_lane_en)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Drive one controller cycle at the falling edge, then let outputs settle
   task automatic step(input logic [3:0] cmd, input logic [7:0] dqm = 8'h00,
                       input logic [12:0] addr = 13'h0, input logic cke = 1'b1,
                       input logic [63:0] wd = 64'h0);
      @(negedge clk);
      {c_cs_n, c_ras_n, c_cas_n, c_we_n} = cmd;
      c_dqm = dqm; c_addr = addr; c_cke = cke; c_wdata = wd;
      #1;
   endtask

   task automatic set_mode(input logic b, input logic [CL_W-1:0] cl);
      @(negedge clk);
      {c_cs_n, c_ras_n, c_cas_n, c_we_n} = NOP;
      c_dqm = '0; bypass = b; cas_lat = cl;
      #1;
      chk("R12 switch cycle command", {60'h0, d_cs_n, d_ras_n, d_cas_n, d_we_n}, 64'h7);
      step(NOP); step(NOP); step(NOP);
   endtask

   task automatic t_reset;
      step(NOP); step(NOP);
      chk("R1 reset cs/strobes", {60'h0, d_cs_n, d_ras_n, d_cas_n, d_we_n}, 64'hF);
      chk("R1 reset cke", {63'h0, d_cke}, 64'h0);
      chk("R1 reset dqm", {56'h0, d_dqm}, 64'hFF);
      chk("R1 reset strobes", {48'h0, rd_lane_vld, wr_lane_en}, 64'h0);
      @(negedge clk); rst_n = 1'b1;
      step(NOP); step(NOP); step(NOP);
   endtask

   task automatic t_reg_cmd;
      step(ACT, 8'h00, 13'h0ABC);
      chk("R2 not yet at DRAM", {63'h0, d_ras_n}, 64'h1);
      step(NOP);
      chk("R2 strobe one clock later", {60'h0, d_cs_n, d_ras_n, d_cas_n, d_we_n}, {60'h0, ACT});
      chk("R2 address one clock later", {51'h0, d_addr}, 64'h0ABC);
      chk("R2 bank one clock later", {62'h0, d_ba}, 64'h1);
      step(NOP, 8'h00, 13'h0, 1'b0);
      chk("R7 cke still high", {63'h0, d_cke}, 64'h1);
      step(NOP, 8'h00, 13'h0, 1'b0);
      chk("R7 cke low one clock later", {63'h0, d_cke}, 64'h0);
      step(NOP); step(NOP);
      chk("R7 cke restored", {63'h0, d_cke}, 64'h1);
   endtask

   task automatic t_read(input string tag);
      step(RD);
      chk({tag, " no beat at issue"}, {56'h0, rd_lane_vld}, 64'h0);
      for (int i = 1; i <= 9; i++) begin
         step(NOP);
         chk({tag, " beat window"}, {56'h0, rd_lane_vld},
             (i >= int'(rd_lat) && i < int'(rd_lat) + BL) ? 64'hFF : 64'h0);
      end
   endtask

   task automatic t_transparent;
      step(ACT, 8'h00, 13'h1234);
      chk("R3 strobe same cycle", {60'h0, d_cs_n, d_ras_n, d_cas_n, d_we_n}, {60'h0, ACT});
      chk("R3 address same cycle", {51'h0, d_addr}, 64'h1234);
      step(NOP);
      chk("R4 transparent latency", {61'h0, rd_lat}, 64'd3);
      t_read("R5 transparent CL3");
   endtask

   // Second read two cycles later, with a mask on the restarted burst's first beat
   task automatic t_trunc_mask;
      chk("R4 registered latency", {61'h0, rd_lat}, 64'd3);
      step(RD);
      step(NOP);
      step(RD, 8'h3C);
      for (int i = 3; i <= 9; i++) begin
         step(NOP);
         chk("R11 R6 back-to-back beats", {56'h0, rd_lane_vld},
             (i == 5) ? 64'hC3 : (i <= 8 ? 64'hFF : 64'h0));
      end
   endtask

   task automatic t_wr_reg;
      step(WR, 8'h00, 13'h0, 1'b1, 64'hAAAA_0000_5555_0001);
      chk("R8 registered no beat at issue", {56'h0, wr_lane_en}, 64'h0);
      step(NOP, 8'h3C, 13'h0, 1'b1, 64'h1122_3344_5566_7788);
      chk("R9 first beat mask", {56'h0, wr_lane_en}, 64'hFF);
      chk("R8 data passes unregistered", d_wdata, 64'h1122_3344_5566_7788);
      step(NOP);
      chk("R9 second beat mask", {56'h0, wr_lane_en}, 64'hC3);
      step(NOP);
      chk("R8 third beat", {56'h0, wr_lane_en}, 64'hFF);
      step(NOP);
      chk("R8 fourth beat", {56'h0, wr_lane_en}, 64'hFF);
      step(NOP);
      chk("R8 burst ended", {56'h0, wr_lane_en}, 64'h0);
   endtask

   task automatic t_wr_bypass;
      step(WR, 8'h0F, 13'h0, 1'b1, 64'hDEAD_BEEF_0000_0042);
      chk("R9 transparent same-cycle mask", {56'h0, wr_lane_en}, 64'hF0);
      chk("R8 transparent data", d_wdata, 64'hDEAD_BEEF_0000_0042);
      for (int i = 1; i <= 4; i++) begin
         step(NOP);
         chk("R8 transparent beats", {56'h0, wr_lane_en}, (i < BL) ? 64'hFF : 64'h0);
      end
   endtask

   task automatic t_float;
      set_mode(1'bz, 2'd2);
      chk("R10 undriven select latency", {61'h0, rd_lat}, 64'd3);
      step(ACT, 8'h00, 13'h0055);
      chk("R10 undriven select delays command", {63'h0, d_ras_n}, 64'h1);
      step(NOP);
      chk("R10 command arrives next cycle", {51'h0, d_addr}, 64'h0055);
   endtask

   initial begin
      #500000;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_reg_cmd();
      t_read("R5 registered CL2");
      t_trunc_mask();
      t_wr_reg();
      set_mode(1'b1, 2'd3);
      t_transparent();
      t_wr_bypass();
      set_mode(1'b0, 2'd2);
      t_float();
      step(NOP); step(NOP);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule